// File: doc/BRIEF.md
# Six-Control-Bit Preset/Negate ALU

This block is a purely combinational arithmetic-logic unit. It has no encoded opcode. Six independent control bits steer one fixed datapath. Each operand can first be forced to zero and then bit-inverted. The two conditioned operands are then either added or bitwise-ANDed. The result can be bit-inverted at the very end.

From this one structure a decoder obtains constants (0, 1, -1), pass-through, negation, increment, decrement, sum, both differences, AND and OR. Two flags go to a branch unit:
- a zero flag;
- a sign flag.

A branch unit treats the result as strictly positive only when both flags are clear.

The operand width is a parameter and defaults to 16 bits. All values are two's complement.

Top module: `preset_negate_alu`

## Requirements
- R1: When `clr_a` is 1, operand A is replaced by zero before any inversion of A is applied. With `clr_a`=1, `sel_add`=1 and all other controls 0, `result` equals `op_b`.
- R2: When `inv_a` is 1, the (possibly cleared) operand A is bit-inverted. With `inv_a`, `sel_add` and `inv_out` at 1 and the other controls 0, `result` equals `op_a - op_b`.
- R3: `clr_b` zeroes operand B and `inv_b` then bit-inverts it. With `clr_a` and `inv_a` at 0, `clr_b` and `inv_b` at 1 and `sel_add` at 0, `result` equals `op_a`.
- R4: When `sel_add` is 1, the combining stage gives the W-bit sum of the conditioned operands, and the carry out is discarded. For example, 0x7FFF + 0x0001 = 0x8000 and 0xFFFF + 0x0001 = 0x0000.
- R5: When `sel_add` is 0, the combining stage gives the bitwise AND of the conditioned operands. With every control 0, `result` equals `op_a & op_b`.
- R6: When `inv_out` is 1, the output of the combining stage is bit-inverted as the last step. With `inv_a`, `inv_b` and `inv_out` at 1 and `sel_add` at 0, `result` equals `op_a | op_b`.
- R7: `is_zero` is 1 exactly when `result` is all zeros.
- R8: `is_neg` is 1 exactly when the most significant bit of `result` is 1.
- R9: The control word {clr_a,inv_a,clr_b,inv_b,sel_add,inv_out} gives fixed constants for any operands:
  - 101010 gives 0;
  - 111111 gives 1;
  - 111010 gives all ones.
- R10: The block holds no state. Every output reflects the current inputs in the same time step, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand, two's complement |
| op_b | input | W | Second operand, two's complement |
| clr_a | input | 1 | Force operand A to zero |
| inv_a | input | 1 | Bit-invert operand A after the zero stage |
| clr_b | input | 1 | Force operand B to zero |
| inv_b | input | 1 | Bit-invert operand B after the zero stage |
| sel_add | input | 1 | 1 = add, 0 = bitwise AND |
| inv_out | input | 1 | Bit-invert the combined value |
| result | output | W | Unit output |
| is_zero | output | 1 | Result equals zero |
| is_neg | output | 1 | Result sign bit |

## Verification
The bench builds the unit with its default width of 16. At that width the operand corners 0x0000, 0x0001, 0x7FFF, 0x8000 and 0xFFFF land exactly on the sign boundary and on the wrap of the discarded carry.

Every one of the eighteen customary control words is swept across all pairs of these corners and across pseudo-random operands. The expected value comes from the arithmetic meaning of each control word, not from the datapath.

Directed cases then cover the following:
- a zero result with the sign clear;
- operand-independence of the constants;
- outputs that follow an input change without any clock.

// File: rtl/preset_negate_alu.sv
module preset_negate_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         clr_a,
  input  logic         inv_a,
  input  logic         clr_b,
  input  logic         inv_b,
  input  logic         sel_add,
  input  logic         inv_out,
  output logic [W-1:0] result,
  output logic         is_zero,
  output logic         is_neg
);

  logic [W-1:0] a_z, a_c, b_z, b_c, comb;

  assign a_z = clr_a ? '0 : op_a;
  assign a_c = inv_a ? ~a_z : a_z;
  assign b_z = clr_b ? '0 : op_b;
  assign b_c = inv_b ? ~b_z : b_z;

  assign comb    = sel_add ? (a_c + b_c) : (a_c & b_c);
  assign result  = inv_out ? ~comb : comb;

  assign is_zero = ~|result;
  assign is_neg  = result[W-1];

endmodule

module preset_negate_alu_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         clr_a,
  input logic         inv_a,
  input logic         clr_b,
  input logic         inv_b,
  input logic         sel_add,
  input logic         inv_out,
  input logic [W-1:0] result,
  input logic         is_zero,
  input logic         is_neg
);

  logic [5:0] ctl;
  logic       known;

  assign ctl   = {clr_a, inv_a, clr_b, inv_b, sel_add, inv_out};
  assign known = !$isunknown({op_a, op_b, ctl, result, is_zero, is_neg});

  always_comb begin
    if (known) begin
      assert_zero_flag_R7: assert (is_zero == (result == {W{1'b0}}))
        else $error("zero flag disagrees with result");
      assert_sign_flag_R8: assert (is_neg == (result >= (W'(1) << (W-1))))
        else $error("sign flag disagrees with result");
      if (ctl == 6'b111111)
        assert_const_one_R9: assert (result == W'(1))
          else $error("constant one control word");
      if (ctl == 6'b101010)
        assert_const_zero_R9: assert (result == W'(0))
          else $error("constant zero control word");
      if (ctl == 6'b100010)
        assert_pass_b_R1: assert (result == op_b)
          else $error("cleared A plus B must pass B");
      if (ctl == 6'b000000)
        assert_and_R5: assert (result == (op_a & op_b))
          else $error("AND function");
      if (ctl == 6'b010101)
        assert_or_R6: assert (result == (op_a | op_b))
          else $error("OR via output inversion");
    end
  end

endmodule

bind preset_negate_alu preset_negate_alu_chk #(.W(W)) u_chk (
  .op_a(op_a), .op_b(op_b), .clr_a(clr_a), .inv_a(inv_a),
  .clr_b(clr_b), .inv_b(inv_b), .sel_add(sel_add), .inv_out(inv_out),
  .result(result), .is_zero(is_zero), .is_neg(is_neg)
);

// File: tb/preset_negate_alu_tb.sv
module preset_negate_alu_tb;

  localparam int W        = 16;
  localparam int CLK_HALF = 5;
  localparam int NOPS     = 18;
  localparam int NCORN    = 5;
  localparam int NRAND    = 24;

  // control words {clr_a,inv_a,clr_b,inv_b,sel_add,inv_out}; meaning by index
  localparam logic [5:0] CTL [NOPS] = '{
    6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
    6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
    6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101
  };
  localparam logic [W-1:0] CORN [NCORN] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

  logic clk = 1'b0;
  always #CLK_HALF clk = ~clk;

  logic [W-1:0] op_a, op_b, result;
  logic clr_a, inv_a, clr_b, inv_b, sel_add, inv_out, is_zero, is_neg;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  preset_negate_alu #(.W(W)) u_dut (
    .op_a(op_a), .op_b(op_b), .clr_a(clr_a), .inv_a(inv_a),
    .clr_b(clr_b), .inv_b(inv_b), .sel_add(sel_add), .inv_out(inv_out),
    .result(result), .is_zero(is_zero), .is_neg(is_neg)
  );

  function automatic logic [W-1:0] expect_val(int k, logic [W-1:0] a, logic [W-1:0] b);
    case (k)
      0:  return 16'h0000;
      1:  return 16'h0001;
      2:  return 16'hFFFF;
      3:  return a;
      4:  return b;
      5:  return ~a;
      6:  return ~b;
      7:  return 16'h0000 - a;
      8:  return 16'h0000 - b;
      9:  return a + 16'h0001;
      10: return b + 16'h0001;
      11: return a - 16'h0001;
      12: return b - 16'h0001;
      13: return a + b;
      14: return a - b;
      15: return b - a;
      16: return a & b;
      default: return a | b;
    endcase
  endfunction

  function automatic string req_of(int k);
    case (k)
      0, 1, 2: return "R9";
      3:  return "R3";
      4:  return "R1";
      5, 6, 7, 8, 14, 15: return "R2";
      9, 10, 11, 12, 13: return "R4";
      16: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [5:0] c, logic [W-1:0] a, logic [W-1:0] b);
    {clr_a, inv_a, clr_b, inv_b, sel_add, inv_out} = c;
    op_a = a;
    op_b = b;
    #1;
  endtask

  task automatic run_vec(int k, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] e;
    e = expect_val(k, a, b);
    apply(CTL[k], a, b);
    check(req_of(k), result, e);
    check("R7", W'(is_zero), W'(e == 16'h0000));
    check("R8", W'(is_neg), W'(e[W-1]));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    apply(6'b000000, 16'h0000, 16'h0000);
    check("R7", W'(is_zero), 16'h0001);
    check("R8", W'(is_neg), 16'h0000);

    for (int k = 0; k < NOPS; k++) begin
      for (int i = 0; i < NCORN; i++)
        for (int j = 0; j < NCORN; j++)
          run_vec(k, CORN[i], CORN[j]);
      for (int r = 0; r < NRAND; r++) begin
        ra = W'($urandom);
        rb = W'($urandom);
        run_vec(k, ra, rb);
      end
    end

    // R4: carry out discarded at the wrap
    apply(6'b000010, 16'h7FFF, 16'h0001);
    check("R4", result, 16'h8000);
    check("R8", W'(is_neg), 16'h0001);
    apply(6'b000010, 16'hFFFF, 16'h0001);
    check("R4", result, 16'h0000);
    check("R7", W'(is_zero), 16'h0001);

    // R7/R8: equal operands subtract to zero, sign clear
    apply(6'b010011, 16'h1234, 16'h1234);
    check("R7", W'(is_zero), 16'h0001);
    check("R8", W'(is_neg), 16'h0000);

    // R9: constants ignore operands
    apply(6'b111111, 16'hA5A5, 16'h5A5A);
    check("R9", result, 16'h0001);
    apply(6'b101010, 16'hFFFF, 16'hFFFF);
    check("R9", result, 16'h0000);
    apply(6'b111010, 16'h0000, 16'h8000);
    check("R9", result, 16'hFFFF);

    // R1: zero stage precedes inversion (clr+inv of A, AND with B gives B)
    apply(6'b110000, 16'h0F0F, 16'h3C3C);
    check("R1", result, 16'h3C3C);

    // R10: outputs follow inputs with no clock edge in between
    @(negedge clk);
    apply(6'b000010, 16'h0002, 16'h0003);
    check("R10", result, 16'h0005);
    op_b = 16'h0010;
    #1;
    check("R10", result, 16'h0012);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule